// File: doc/BRIEF.md
# Store-Load Ordering Monitor

This block is a synthesizable runtime checker that sits beside a memory request and service interface and watches a single address. It looks for one hazard: a store to that address is requested, a load to the same address is then requested, and the load is serviced while the store is still waiting for its service. When that happens the checker enters a terminal error state and raises a sticky error flag. The flag stays high until reset.

Four strobe channels feed the checker: store request, store service, load request and load service. Each channel carries its own address. The watched address is a static input, and a channel only counts as an event when its address equals that value. A small sequence machine tracks how far the hazard has progressed. A store service to the watched address always cancels a pending hazard. Because the machine returns to its idle state after each cancellation, it can detect a violation that begins anywhere in a long trace, not only just after reset.

The current state is exported on a 2-bit port so that a higher-level environment can observe the progress of the hazard.

Top module: `slm_monitor`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes IDLE (encoding 2'b00) and `err` is 0 afterwards.
- R2: In IDLE, a matching store request with no matching store service in the same cycle moves the state to STORE_PEND (2'b01).
- R3: In STORE_PEND, a matching load request with no matching store service in the same cycle moves the state to LOAD_PEND (2'b10).
- R4: In LOAD_PEND, a matching load service with no matching store service in the same cycle moves the state to BAD (2'b11).
- R5: A matching store service in STORE_PEND or LOAD_PEND returns the state to IDLE. It takes priority over every other event in the same cycle. In IDLE, a matching store service keeps the state at IDLE, even when a matching store request arrives in the same cycle.
- R6: In a non-BAD state, a cycle without a matching event that the state reacts to leaves the state unchanged. This includes a load service in STORE_PEND, any load event in IDLE, and a store or load request in LOAD_PEND.
- R7: Once the state is BAD, it stays BAD on every later cycle until reset, whatever the inputs.
- R8: A strobe whose address differs from `watch_addr` has no effect on the state.
- R9: `err` is 1 exactly while the state is BAD.
- R10: After the state returns to IDLE following a cancelled hazard, a later store request, load request and load service sequence to the watched address is still detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| watch_addr | input | ADDR_W | Address being monitored, held static |
| st_req_vld | input | 1 | Store request strobe |
| st_req_addr | input | ADDR_W | Store request address |
| st_svc_vld | input | 1 | Store service strobe |
| st_svc_addr | input | ADDR_W | Store service address |
| ld_req_vld | input | 1 | Load request strobe |
| ld_req_addr | input | ADDR_W | Load request address |
| ld_svc_vld | input | 1 | Load service strobe |
| ld_svc_addr | input | ADDR_W | Load service address |
| err | output | 1 | Sticky ordering-violation flag |
| state | output | 2 | Current checker state (00 IDLE, 01 STORE_PEND, 10 LOAD_PEND, 11 BAD) |

## Verification
The directed patterns each isolate one path:
- The plain violating sequence separates a working detector from one that never reaches BAD.
- The same sequence with a store service inserted at each pending stage tells a proper cancel apart from a missing or misplaced one.
- Same-cycle collisions between the store service and the other strobes expose the wrong priority.
- The same strobes aimed at a different address show whether the address filter is working.

A long run of random strobes, split between the watched address and one other, is then compared on every clock against a behavioural model. This catches errors in rarely visited combinations, in re-arming after a cancel, and in holding the BAD state.

// File: rtl/slm_pkg.sv
package slm_pkg;

    typedef enum logic [1:0] {
        SLM_IDLE       = 2'b00,
        SLM_STORE_PEND = 2'b01,
        SLM_LOAD_PEND  = 2'b10,
        SLM_BAD        = 2'b11
    } slm_state_e;

    localparam int unsigned SLM_NUM_CH = 4;
    localparam int unsigned CH_ST_REQ  = 0;
    localparam int unsigned CH_ST_SVC  = 1;
    localparam int unsigned CH_LD_REQ  = 2;
    localparam int unsigned CH_LD_SVC  = 3;

    typedef struct packed {
        logic st_req;
        logic st_svc;
        logic ld_req;
        logic ld_svc;
    } slm_evt_t;

    typedef struct packed {
        slm_state_e state;
    } slm_regs_t;

endpackage

// File: rtl/slm_match.sv
module slm_match
    import slm_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned NUM_CH = SLM_NUM_CH
) (
    input  logic [ADDR_W-1:0]             watch_addr,
    input  logic [NUM_CH-1:0]             ch_vld,
    input  logic [NUM_CH-1:0][ADDR_W-1:0] ch_addr,
    output logic [NUM_CH-1:0]             ch_hit
);

    // One comparator per channel; a channel counts only if strobed and addressed to the watched word.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        assign ch_hit[g] = ch_vld[g] && (ch_addr[g] == watch_addr);
    end

endmodule

// File: rtl/slm_next.sv
module slm_next
    import slm_pkg::*;
(
    input  slm_state_e state_q,
    input  slm_evt_t   evt,
    output slm_state_e state_d
);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLM_IDLE: begin
                // Service wins over a same-cycle store request.
                if (evt.st_req && !evt.st_svc) state_d = SLM_STORE_PEND;
            end
            SLM_STORE_PEND: begin
                if (evt.st_svc)      state_d = SLM_IDLE;
                else if (evt.ld_req) state_d = SLM_LOAD_PEND;
            end
            SLM_LOAD_PEND: begin
                if (evt.st_svc)      state_d = SLM_IDLE;
                else if (evt.ld_svc) state_d = SLM_BAD;
            end
            SLM_BAD: state_d = SLM_BAD;
            default: state_d = SLM_IDLE;
        endcase
    end

endmodule

// File: rtl/slm_monitor.sv
module slm_monitor
    import slm_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] watch_addr,
    input  logic              st_req_vld,
    input  logic [ADDR_W-1:0] st_req_addr,
    input  logic              st_svc_vld,
    input  logic [ADDR_W-1:0] st_svc_addr,
    input  logic              ld_req_vld,
    input  logic [ADDR_W-1:0] ld_req_addr,
    input  logic              ld_svc_vld,
    input  logic [ADDR_W-1:0] ld_svc_addr,
    output logic              err,
    output logic [1:0]        state
);

    localparam int unsigned NCH = SLM_NUM_CH;

    logic [NCH-1:0]             ch_vld;
    logic [NCH-1:0][ADDR_W-1:0] ch_addr;
    logic [NCH-1:0]             ch_hit;
    slm_evt_t                   evt;
    slm_state_e                 nxt_state;
    slm_regs_t                  regs_d;
    slm_regs_t                  regs_q;

    always_comb begin
        ch_vld              = '0;
        ch_addr             = '0;
        ch_vld[CH_ST_REQ]   = st_req_vld;
        ch_addr[CH_ST_REQ]  = st_req_addr;
        ch_vld[CH_ST_SVC]   = st_svc_vld;
        ch_addr[CH_ST_SVC]  = st_svc_addr;
        ch_vld[CH_LD_REQ]   = ld_req_vld;
        ch_addr[CH_LD_REQ]  = ld_req_addr;
        ch_vld[CH_LD_SVC]   = ld_svc_vld;
        ch_addr[CH_LD_SVC]  = ld_svc_addr;
    end

    slm_match #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NCH)
    ) u_match (
        .watch_addr (watch_addr),
        .ch_vld     (ch_vld),
        .ch_addr    (ch_addr),
        .ch_hit     (ch_hit)
    );

    always_comb begin
        evt.st_req = ch_hit[CH_ST_REQ];
        evt.st_svc = ch_hit[CH_ST_SVC];
        evt.ld_req = ch_hit[CH_LD_REQ];
        evt.ld_svc = ch_hit[CH_LD_SVC];
    end

    slm_next u_next (
        .state_q (regs_q.state),
        .evt     (evt),
        .state_d (nxt_state)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = nxt_state;
        if (rst) regs_d.state = SLM_IDLE;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign state = regs_q.state;
    assign err   = (regs_q.state == SLM_BAD);

    // R1: reset lands in IDLE
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state == 2'b00 && !err));

    // R2: matched store request from IDLE arms the checker
    a_r2_arm: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b00 && st_req_vld && st_req_addr == watch_addr &&
         !(st_svc_vld && st_svc_addr == watch_addr)) |=> state == 2'b01);

    // R4: matched load service in LOAD_PEND without store service is a violation
    a_r4_detect: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b10 && ld_svc_vld && ld_svc_addr == watch_addr &&
         !(st_svc_vld && st_svc_addr == watch_addr)) |=> err);

    // R5: store service cancels a pending hazard
    a_r5_cancel: assert property (@(posedge clk) disable iff (rst)
        ((state == 2'b01 || state == 2'b10) &&
         st_svc_vld && st_svc_addr == watch_addr) |=> state == 2'b00);

    // R7: BAD is absorbing
    a_r7_bad_hold: assert property (@(posedge clk) disable iff (rst)
        err |=> (err && state == 2'b11));

    // R9: the flag only rises out of LOAD_PEND
    a_r9_err_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(state) == 2'b10);

endmodule

// File: tb/tb_slm_monitor.sv
module tb_slm_monitor;

    localparam int unsigned AW = 16;
    localparam logic [AW-1:0] WADDR = 16'h1A40;
    localparam logic [AW-1:0] OADDR = 16'h1A44;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] watch_addr;
    logic          st_req_vld, st_svc_vld, ld_req_vld, ld_svc_vld;
    logic [AW-1:0] st_req_addr, st_svc_addr, ld_req_addr, ld_svc_addr;
    logic          err;
    logic [1:0]    state;

    int checks   = 0;
    int failures = 0;
    int model    = 0;
    int cycles   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    slm_monitor #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .watch_addr(watch_addr),
        .st_req_vld(st_req_vld), .st_req_addr(st_req_addr),
        .st_svc_vld(st_svc_vld), .st_svc_addr(st_svc_addr),
        .ld_req_vld(ld_req_vld), .ld_req_addr(ld_req_addr),
        .ld_svc_vld(ld_svc_vld), .ld_svc_addr(ld_svc_addr),
        .err(err), .state(state)
    );

    // Behavioural reference: 0 idle, 1 store waiting, 2 load waiting behind store, 3 violation.
    function automatic int ref_next(int s, bit r, bit sq, bit ss, bit lq, bit ls);
        if (r) return 0;
        if (s == 3) return 3;
        if (ss) return 0;
        if (s == 0 && sq) return 1;
        if (s == 1 && lq) return 2;
        if (s == 2 && ls) return 3;
        return s;
    endfunction

    task automatic check(string req);
        checks++;
        if (state !== model[1:0] || err !== (model == 3)) begin
            failures++;
            $display("FAIL %s: state=%0d err=%0b expected state=%0d err=%0b",
                     req, state, err, model, (model == 3));
        end
    endtask

    // Drive one cycle at the falling edge, let it register, compare at the next falling edge.
    task automatic step(string req, bit r, bit sq, logic [AW-1:0] sqa, bit ss, logic [AW-1:0] ssa,
                        bit lq, logic [AW-1:0] lqa, bit ls, logic [AW-1:0] lsa);
        rst = r;
        st_req_vld = sq; st_req_addr = sqa;
        st_svc_vld = ss; st_svc_addr = ssa;
        ld_req_vld = lq; ld_req_addr = lqa;
        ld_svc_vld = ls; ld_svc_addr = lsa;
        model = ref_next(model, r, sq && sqa == watch_addr, ss && ssa == watch_addr,
                         lq && lqa == watch_addr, ls && lsa == watch_addr);
        @(posedge clk);
        @(negedge clk);
        check(req);
    endtask

    task automatic idle_cyc(string req);
        step(req, 0, 0, WADDR, 0, WADDR, 0, WADDR, 0, WADDR);
    endtask

    task automatic do_reset();
        step("R1", 1, 0, WADDR, 0, WADDR, 0, WADDR, 0, WADDR);
    endtask

    initial begin
        watch_addr = WADDR;
        rst = 1'b1;
        {st_req_vld, st_svc_vld, ld_req_vld, ld_svc_vld} = '0;
        {st_req_addr, st_svc_addr, ld_req_addr, ld_svc_addr} = '0;
        @(negedge clk);
        do_reset();
        do_reset();

        // R2 R3 R4 R6 R7 R9: plain violation with quiet gaps, then hold
        step("R2", 0, 1, WADDR, 0, WADDR, 0, WADDR, 0, WADDR);
        idle_cyc("R6");
        step("R6", 0, 0, WADDR, 0, WADDR, 0, WADDR, 1, WADDR);
        step("R3", 0, 0, WADDR, 0, WADDR, 1, WADDR, 0, WADDR);
        step("R6", 0, 1, WADDR, 0, WADDR, 1, WADDR, 0, WADDR);
        step("R4", 0, 0, WADDR, 0, WADDR, 0, WADDR, 1, WADDR);
        step("R7", 0, 0, WADDR, 1, WADDR, 0, WADDR, 0, WADDR);
        step("R7", 0, 1, WADDR, 1, WADDR, 1, WADDR, 1, WADDR);
        idle_cyc("R9");
        do_reset();

        // R5: cancel from STORE_PEND, then R10 re-arm and detect
        step("R2", 0, 1, WADDR, 0, WADDR, 0, WADDR, 0, WADDR);
        step("R5", 0, 0, WADDR, 1, WADDR, 1, WADDR, 0, WADDR);
        step("R6", 0, 0, WADDR, 0, WADDR, 1, WADDR, 1, WADDR);
        step("R10", 0, 1, WADDR, 0, WADDR, 0, WADDR, 0, WADDR);
        step("R10", 0, 0, WADDR, 0, WADDR, 1, WADDR, 0, WADDR);
        // R5: cancel from LOAD_PEND beats a same-cycle load service
        step("R5", 0, 0, WADDR, 1, WADDR, 0, WADDR, 1, WADDR);
        step("R10", 0, 1, WADDR, 0, WADDR, 0, WADDR, 0, WADDR);
        step("R10", 0, 0, WADDR, 0, WADDR, 1, WADDR, 0, WADDR);
        step("R10", 0, 0, WADDR, 0, WADDR, 0, WADDR, 1, WADDR);
        do_reset();

        // R5: request and service together in IDLE stay IDLE
        step("R5", 0, 1, WADDR, 1, WADDR, 0, WADDR, 0, WADDR);

        // R8: same pattern to another address changes nothing
        step("R8", 0, 1, OADDR, 0, WADDR, 0, WADDR, 0, WADDR);
        step("R2", 0, 1, WADDR, 0, WADDR, 0, WADDR, 0, WADDR);
        step("R8", 0, 0, WADDR, 1, OADDR, 1, OADDR, 0, WADDR);
        step("R3", 0, 0, WADDR, 0, WADDR, 1, WADDR, 0, WADDR);
        step("R8", 0, 0, WADDR, 1, OADDR, 0, WADDR, 1, OADDR);
        step("R8", 0, 0, WADDR, 0, WADDR, 1, OADDR, 0, WADDR);
        step("R4", 0, 0, WADDR, 1, OADDR, 0, WADDR, 1, WADDR);
        do_reset();

        // Random traffic across both addresses, compared each cycle
        for (int i = 0; i < 4000; i++) begin
            automatic bit r = ($urandom_range(0, 199) == 0);
            step("R10", r,
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) != 0) ? WADDR : OADDR,
                 ($urandom_range(0, 4) == 0), ($urandom_range(0, 1) != 0) ? WADDR : OADDR,
                 ($urandom_range(0, 2) == 0), ($urandom_range(0, 1) != 0) ? WADDR : OADDR,
                 ($urandom_range(0, 2) == 0), ($urandom_range(0, 1) != 0) ? WADDR : OADDR);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 50000) begin
            checks++;
            failures++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule